// File: doc/BRIEF.md
# Virtually Indexed Way-Location Table

This block is a small direct-mapped table that remembers, for recently used memory lines, which way of a large set-associative second-level cache holds each line. It keeps only a way number per entry, never line data. Both the entry index and the stored tag come from the virtual address. The lookup therefore runs in the same cycle as address translation and the first-level cache access, and does not wait for the physical address.

On a lookup the table returns, one cycle later, a hit flag and a way number. On a hit the caller passes that way to the second-level cache together with the translated address, so the cache is probed as if it were direct-mapped. On a miss no way is supplied, and the cache must be probed across all its ways. When a second-level access completes, the caller writes the way that actually held the line through the update port. A flush input invalidates the whole table. Snoops that change line contents need no action here, because a line's location does not change.

Top module: `way_loc_table`

## Requirements
- R1: After reset every entry is invalid, `resultValid` is 0, and every lookup misses until an update is made.
- R2: `resultValid` is asserted in exactly the cycle after a cycle with `lookupValid` high, and is 0 otherwise.
- R3: A lookup whose virtual line matches the last update to its entry returns `resultHit`=1 and the way that was written.
- R4: A lookup that selects an entry holding a different tag, or an invalid entry, returns `resultHit`=0.
- R5: An update overwrites the tag and way of its entry regardless of the previous occupant, so the old line then misses.
- R6: An update and a lookup in the same cycle to the same entry are forwarded. The lookup hits with the new way if the tags match, and misses if they differ. Updates to other entries leave the lookup unaffected.
- R7: `flush` clears every entry. A lookup in the flush cycle misses, and an update in the flush cycle is discarded.
- R8: The address splits as offset = bits [OFS_W-1:0] (ignored), index = bits [OFS_W+IDX_W-1:OFS_W], tag = bits [VADDR_W-1:OFS_W+IDX_W]. The defaults are OFS_W=6 and 16 entries (IDX_W=4).
- R9: `resultWay` is 0 whenever `resultHit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| lookupValid | input | 1 | Lookup request strobe |
| lookupVaddr | input | VADDR_W | Virtual address to look up |
| updateValid | input | 1 | Update request strobe |
| updateVaddr | input | VADDR_W | Virtual address of the completed access |
| updateWay | input | WAY_W | Way that held the line |
| resultValid | output | 1 | Lookup result present (one cycle after request) |
| resultHit | output | 1 | Location known |
| resultWay | output | WAY_W | Way number on a hit, zero on a miss |

## Verification
The assertions assume that `flush`, `lookupValid` and `updateValid` carry known values in every cycle after reset. They also assume that `updateWay` is stable across the edge where a forwarded update is captured. The bench drives every input only just after the falling clock edge, and always gives the strobes a defined 0 or 1. Lookup and update addresses are drawn from a narrow tag range so that hits, aliasing, overwrites and same-cycle forwarding all occur often.

// File: rtl/way_loc_pkg.sv
package way_loc_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic writeEn;
    logic clearAll;
    logic capture;
    logic fwdHit;
    logic fwdMiss;
  } wlStrobes_t;

  // address comparison results from datapath to control
  typedef struct packed {
    logic sameIdx;
    logic sameTag;
  } wlCompare_t;

endpackage

// File: rtl/way_loc_ctrl.sv
module way_loc_ctrl
  import way_loc_pkg::*;
(
  input  logic       flush,
  input  logic       lookupValid,
  input  logic       updateValid,
  input  wlCompare_t cmp,
  output wlStrobes_t strb
);

  logic liveUpdate;

  always_comb begin
    liveUpdate    = updateValid && !flush;
    strb.clearAll = flush;
    strb.writeEn  = liveUpdate;
    strb.capture  = lookupValid;
    strb.fwdHit   = liveUpdate && lookupValid && cmp.sameIdx && cmp.sameTag;
    strb.fwdMiss  = liveUpdate && lookupValid && cmp.sameIdx && !cmp.sameTag;
  end

endmodule

// File: rtl/way_loc_dp.sv
module way_loc_dp
  import way_loc_pkg::*;
#(
  parameter int VADDR_W = 32,
  parameter int OFS_W   = 6,
  parameter int ENTRIES = 16,
  parameter int WAYS    = 8,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int TAG_W  = VADDR_W - OFS_W - IDX_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [VADDR_W-1:0] lookupVaddr,
  input  logic [VADDR_W-1:0] updateVaddr,
  input  logic [WAY_W-1:0]   updateWay,
  input  wlStrobes_t         strb,
  output wlCompare_t         cmp,
  output logic               resultValid,
  output logic               resultHit,
  output logic [WAY_W-1:0]   resultWay
);

  logic [IDX_W-1:0] lookIdx, updIdx;
  logic [TAG_W-1:0] lookTag, updTag;
  logic             unusedOfsBits;

  assign lookIdx = lookupVaddr[OFS_W +: IDX_W];
  assign updIdx  = updateVaddr[OFS_W +: IDX_W];
  assign lookTag = lookupVaddr[VADDR_W-1 -: TAG_W];
  assign updTag  = updateVaddr[VADDR_W-1 -: TAG_W];
  assign unusedOfsBits = ^{lookupVaddr[OFS_W-1:0], updateVaddr[OFS_W-1:0]};

  assign cmp.sameIdx = (lookIdx == updIdx);
  assign cmp.sameTag = (lookTag == updTag);

  logic [ENTRIES-1:0] validBits;
  logic [TAG_W-1:0]   tagMem [ENTRIES];
  logic [WAY_W-1:0]   wayMem [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : gEntry
    logic selUpd;
    assign selUpd = strb.writeEn && (updIdx == IDX_W'(e));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              validBits[e] <= 1'b0;
      else if (strb.clearAll) validBits[e] <= 1'b0;
      else if (selUpd)        validBits[e] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (selUpd) begin
        tagMem[e] <= updTag;
        wayMem[e] <= updateWay;
      end
    end
  end

  logic             storedHit;
  logic             nextHit;
  logic [WAY_W-1:0] nextWay;

  always_comb begin
    storedHit = validBits[lookIdx] && (tagMem[lookIdx] == lookTag);
    nextHit   = 1'b0;
    nextWay   = '0;
    if (!strb.clearAll) begin
      if (strb.fwdHit) begin
        nextHit = 1'b1;
        nextWay = updateWay;
      end else if (!strb.fwdMiss && storedHit) begin
        nextHit = 1'b1;
        nextWay = wayMem[lookIdx];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultValid <= 1'b0;
      resultHit   <= 1'b0;
      resultWay   <= '0;
    end else begin
      resultValid <= strb.capture;
      resultHit   <= strb.capture && nextHit;
      resultWay   <= strb.capture ? nextWay : '0;
    end
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> resultValid);
  assert_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> !resultValid);
  assert_fwd_onehot_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.fwdHit, strb.fwdMiss}));
  assert_fwd_hit_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fwdHit && strb.capture) |=> (resultHit && resultWay == $past(updateWay)));
  assert_flush_miss_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearAll |=> !resultHit);
  assert_flush_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearAll |=> (validBits == '0));
  assert_miss_way_R9: assert property (@(posedge clk) disable iff (!rstN)
    !resultHit |-> (resultWay == '0));

endmodule

// File: rtl/way_loc_table.sv
module way_loc_table
  import way_loc_pkg::*;
#(
  parameter int VADDR_W = 32,
  parameter int OFS_W   = 6,
  parameter int ENTRIES = 16,
  parameter int WAYS    = 8,
  localparam int WAY_W  = $clog2(WAYS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               flush,
  input  logic               lookupValid,
  input  logic [VADDR_W-1:0] lookupVaddr,
  input  logic               updateValid,
  input  logic [VADDR_W-1:0] updateVaddr,
  input  logic [WAY_W-1:0]   updateWay,
  output logic               resultValid,
  output logic               resultHit,
  output logic [WAY_W-1:0]   resultWay
);

  wlStrobes_t strb;
  wlCompare_t cmp;

  way_loc_ctrl uCtrl (
    .flush       (flush),
    .lookupValid (lookupValid),
    .updateValid (updateValid),
    .cmp         (cmp),
    .strb        (strb)
  );

  way_loc_dp #(
    .VADDR_W (VADDR_W),
    .OFS_W   (OFS_W),
    .ENTRIES (ENTRIES),
    .WAYS    (WAYS)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .lookupVaddr (lookupVaddr),
    .updateVaddr (updateVaddr),
    .updateWay   (updateWay),
    .strb        (strb),
    .cmp         (cmp),
    .resultValid (resultValid),
    .resultHit   (resultHit),
    .resultWay   (resultWay)
  );

endmodule

// File: tb/way_loc_table_test.sv
`timescale 1ns/1ps
module way_loc_table_test;

  localparam int VADDR_W = 32;
  localparam int OFS_W   = 6;
  localparam int ENTRIES = 16;
  localparam int WAYS    = 8;
  localparam int IDX_W   = 4;
  localparam int WAY_W   = 3;
  localparam int TAG_W   = VADDR_W - OFS_W - IDX_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic flush = 1'b0, lookupValid = 1'b0, updateValid = 1'b0;
  logic [VADDR_W-1:0] lookupVaddr = '0, updateVaddr = '0;
  logic [WAY_W-1:0] updateWay = '0;
  logic resultValid, resultHit;
  logic [WAY_W-1:0] resultWay;

  always #4 clk = ~clk;

  way_loc_table #(.VADDR_W(VADDR_W), .OFS_W(OFS_W), .ENTRIES(ENTRIES), .WAYS(WAYS)) uut (
    .clk(clk), .rstN(rstN), .flush(flush),
    .lookupValid(lookupValid), .lookupVaddr(lookupVaddr),
    .updateValid(updateValid), .updateVaddr(updateVaddr), .updateWay(updateWay),
    .resultValid(resultValid), .resultHit(resultHit), .resultWay(resultWay)
  );

  int vectors = 0;
  int errors  = 0;
  bit mValid [ENTRIES];
  logic [TAG_W-1:0] mTag [ENTRIES];
  logic [WAY_W-1:0] mWay [ENTRIES];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [VADDR_W-1:0] mkAddr(input int tag, input int idx, input int ofs);
    return {TAG_W'(tag), IDX_W'(idx), OFS_W'(ofs)};
  endfunction

  // one cycle: drive after negedge, model, check at following negedge
  task automatic step(input bit lv, input int lt, input int li, input int lo,
                      input bit uv, input int ut, input int ui, input int uw,
                      input bit fl, input string req);
    bit eHit;
    int eWay;
    lookupValid = lv; lookupVaddr = mkAddr(lt, li, lo);
    updateValid = uv; updateVaddr = mkAddr(ut, ui, lo ^ 5); updateWay = WAY_W'(uw);
    flush = fl;
    eHit = 0; eWay = 0;
    if (!fl) begin
      if (uv && ui == li) begin
        eHit = (TAG_W'(ut) == TAG_W'(lt));
        eWay = eHit ? uw : 0;
      end else if (mValid[li] && mTag[li] == TAG_W'(lt)) begin
        eHit = 1; eWay = int'(mWay[li]);
      end
    end
    if (fl) begin
      for (int k = 0; k < ENTRIES; k++) mValid[k] = 0;
    end else if (uv) begin
      mValid[ui] = 1; mTag[ui] = TAG_W'(ut); mWay[ui] = WAY_W'(uw);
    end
    @(negedge clk);
    lookupValid = 0; updateValid = 0; flush = 0;
    check(resultValid == lv, "R2", int'(resultValid), int'(lv));
    if (lv) begin
      check(resultHit == eHit, req, int'(resultHit), int'(eHit));
      check(int'(resultWay) == eWay, req, int'(resultWay), eWay);
    end
    if (!resultHit) check(resultWay == '0, "R9", int'(resultWay), 0);
  endtask

  bit finished = 0;

  initial begin
    #(200000 * 8);
    if (!finished) begin
      errors++; vectors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < ENTRIES; k++) begin mValid[k] = 0; mTag[k] = '0; mWay[k] = '0; end
    repeat (3) @(negedge clk);
    check(resultValid == 1'b0, "R1", int'(resultValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    // R1: all entries miss after reset
    for (int i = 0; i < ENTRIES; i++) step(1, i, i, 0, 0, 0, 0, 0, 0, "R1");
    // R2: idle cycle gives no result
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    // R3/R8: fill every entry, look up with varied offsets
    for (int i = 0; i < ENTRIES; i++) step(0, 0, 0, 0, 1, i + 3, i, i % WAYS, 0, "R3");
    for (int i = 0; i < ENTRIES; i++)
      for (int o = 0; o < 64; o += 21) step(1, i + 3, i, o, 0, 0, 0, 0, 0, "R8");
    // R4: aliasing tag in the same entry misses
    for (int i = 0; i < ENTRIES; i++) step(1, i + 100, i, 0, 0, 0, 0, 0, 0, "R4");
    // R5: overwrite, old line misses, new one hits
    for (int i = 0; i < ENTRIES; i++) step(0, 0, 0, 0, 1, i + 50, i, 7 - (i % WAYS), 0, "R5");
    for (int i = 0; i < ENTRIES; i++) begin
      step(1, i + 3, i, 0, 0, 0, 0, 0, 0, "R5");
      step(1, i + 50, i, 0, 0, 0, 0, 0, 0, "R5");
    end
    // R6: same-cycle forwarding, all ways
    for (int w = 0; w < WAYS; w++) begin
      step(1, 9, 2, 0, 1, 9, 2, w, 0, "R6");
      step(1, 9, 2, 0, 1, 77, 2, w, 0, "R6");
      step(1, 52, 3, 0, 1, 9, 4, w, 0, "R6");
    end
    // R7: flush with lookup and update in the same cycle
    step(1, 53, 3, 0, 1, 60, 5, 2, 1, "R7");
    for (int i = 0; i < ENTRIES; i++) step(1, i + 50, i, 0, 0, 0, 0, 0, 0, "R7");
    step(1, 60, 5, 0, 0, 0, 0, 0, 0, "R7");
    // mixed random traffic over a narrow tag range
    for (int n = 0; n < 3000; n++) begin
      step($urandom_range(0, 3) != 0, $urandom_range(0, 3), $urandom_range(0, 15), $urandom_range(0, 63),
           $urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 15), $urandom_range(0, 7),
           $urandom_range(0, 99) == 0, "R6");
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule